// File: doc/BRIEF.md
# Iterative Quadratic-Rotation Block Cipher Core

This core encrypts one block of four w-bit words per request. The block's words go through a short whitening step, then r identical rounds, then a final whitening step. Each round squares-and-mixes two of the words, XORs them into the other two, and rotates each of those by an amount that depends on the data. The core finishes one round per clock. It holds 2r+4 round keys in two internal single-port key banks. Keys with even index live in one bank and keys with odd index in the other. This lets the two keys a round needs come out of the same cycle's reads.

Software or a neighbouring block first writes every round key, one key per clock, by index. Writing a block then starts an encryption with no further command. r+2 clock edges later, a one-cycle completion pulse marks the new ciphertext on the output register. That register holds the ciphertext until the next encryption completes.

Top module: `wordmix_cipher`

## Requirements
- R1: While reset is applied and just after it is released, `blk_out` reads all zero and `done` is low.
- R2: A key write with `key_we` high stores `key_data` as round key number `key_idx`. Index bit 0 selects the bank (0 for even keys, 1 for odd keys), and bits above it give the word address within that bank.
- R3: Starting an encryption splits `blk_in` into words A (bits 4w-1..3w), B, C and D (bits w-1..0). B is then increased by key 0 and D by key 1, modulo 2^w.
- R4: Round i (1..r) forms T = rotl(B*(2B+1), log2 w) and U = rotl(D*(2D+1), log2 w). It sets A = rotl(A xor T, U mod w) + key 2i and C = rotl(C xor U, T mod w) + key 2i+1, then renames the words so that (A,B,C,D) becomes (B,C,D,A). All arithmetic is modulo 2^w.
- R5: After round r, A is increased by key 2r+2 and C by key 2r+3. The ciphertext is {A,B,C,D}, with A in the top bits.
- R6: `done` is low for the r+1 cycles after the edge that captures `blk_we`. It is high for exactly one cycle after the (r+2)-th edge, counting the capture edge, and `blk_out` carries the new ciphertext in that same cycle.
- R7: `blk_out` changes only in a cycle where `done` is high. Between completions it keeps the last ciphertext.
- R8: A `blk_we` pulse while an encryption is in progress is ignored. The running block's result, and the timing of its single `done` pulse, are unchanged.
- R9: Key writes are dropped while an encryption is in progress and in the cycle that `blk_we` is accepted. The stored keys keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| key_data | input | W | Round key value to store |
| key_idx | input | M = clog2(2r+4) | Round key index, 0..2r+3 |
| key_we | input | 1 | Store `key_data` at `key_idx` this cycle |
| blk_in | input | 4W | Plaintext block, word A in the top bits |
| blk_we | input | 1 | Capture `blk_in` and start an encryption |
| blk_out | output | 4W | Last completed ciphertext, zero before the first |
| done | output | 1 | One-cycle pulse when `blk_out` has just been updated |

## Verification
The assertions assume that keys 0 to 2r+3 have all been written before the first block is started. They also assume that `key_idx` never exceeds 2r+3, so every bank read returns a defined word. The bench writes the full key set right after reset and uses only in-range indices. It does inject block starts and key writes while an encryption is running, which exercises the drop behaviour the assertions rely on rather than breaking their assumptions.

// File: rtl/wmc_pkg.sv
`timescale 1ns/1ps
package wmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_FINAL = 2'd2
  } wmc_state_e;
endpackage

// File: rtl/wmc_key_bank.sv
`timescale 1ns/1ps
// Single-port key bank: one address per cycle, shared by write and read.
module wmc_key_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 10,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(addr) < DEPTH)) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/wmc_round.sv
`timescale 1ns/1ps
// One full round: quadratic mixing, data-dependent rotation, key add, word rename.
module wmc_round #(
  parameter int W = 8,
  parameter int K = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] key_even,
  input  logic [W-1:0] key_odd,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o
);
  function automatic logic [W-1:0] rot_left(input logic [W-1:0] x, input logic [K-1:0] s);
    logic [2*W-1:0] dbl;
    dbl = {x, x} << s;
    return dbl[2*W-1:W];
  endfunction

  logic [W-1:0] b_sq, d_sq, t_mix, u_mix, a_mix, c_mix;

  always_comb begin
    b_sq  = b_i * {b_i[W-2:0], 1'b1};
    d_sq  = d_i * {d_i[W-2:0], 1'b1};
    t_mix = {b_sq[W-K-1:0], b_sq[W-1:W-K]};
    u_mix = {d_sq[W-K-1:0], d_sq[W-1:W-K]};
    a_mix = rot_left(a_i ^ t_mix, u_mix[K-1:0]) + key_even;
    c_mix = rot_left(c_i ^ u_mix, t_mix[K-1:0]) + key_odd;
  end

  assign a_o = b_i;
  assign b_o = c_mix;
  assign c_o = d_i;
  assign d_o = a_mix;
endmodule

// File: rtl/wmc_ctrl.sv
`timescale 1ns/1ps
// Sequencer: load, ROUNDS rounds, final whitening; owns the bank address.
module wmc_ctrl
  import wmc_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          key_we,
  input  logic [AW-1:0] key_addr,
  output logic [AW-1:0] rd_addr,
  output logic          load_en,
  output logic          round_en,
  output logic          final_en,
  output logic          key_wr_ok,
  output logic          done
);
  localparam logic [AW-1:0] LAST_RND = AW'(ROUNDS);
  localparam logic [AW-1:0] FIN_ADDR = AW'(ROUNDS + 1);

  wmc_state_e    state_q, state_d;
  logic [AW-1:0] rnd_q, rnd_d;
  logic          done_q, done_d;

  always_comb begin
    state_d   = state_q;
    rnd_d     = rnd_q;
    done_d    = 1'b0;
    load_en   = 1'b0;
    round_en  = 1'b0;
    final_en  = 1'b0;
    key_wr_ok = 1'b0;
    rd_addr   = key_addr;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          rd_addr = '0;
          rnd_d   = AW'(1);
          state_d = ST_ROUND;
        end else begin
          key_wr_ok = key_we;
        end
      end
      ST_ROUND: begin
        round_en = 1'b1;
        rd_addr  = rnd_q;
        if (rnd_q == LAST_RND) begin
          state_d = ST_FINAL;
        end else begin
          rnd_d = rnd_q + AW'(1);
        end
      end
      ST_FINAL: begin
        final_en = 1'b1;
        rd_addr  = FIN_ADDR;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rnd_q   <= rnd_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_final_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINAL) |=> done_q);
  assert_round_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUND) |-> (rnd_q != '0) && (rnd_q <= LAST_RND));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUND && rnd_q != LAST_RND) |=> (state_q == ST_ROUND));
endmodule

// File: rtl/wordmix_cipher.sv
`timescale 1ns/1ps
module wordmix_cipher #(
  parameter int W      = 8,
  parameter int ROUNDS = 8,
  localparam int NKEYS = 2 * ROUNDS + 4,
  localparam int M     = $clog2(NKEYS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   key_data,
  input  logic [M-1:0]   key_idx,
  input  logic           key_we,
  input  logic [4*W-1:0] blk_in,
  input  logic           blk_we,
  output logic [4*W-1:0] blk_out,
  output logic           done
);
  localparam int K     = $clog2(W);
  localparam int DEPTH = ROUNDS + 2;
  localparam int AW    = M - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [AW-1:0] rd_addr;
  logic          load_en, round_en, final_en, key_wr_ok;
  logic [W-1:0]  key_rd [2];

  wmc_ctrl #(.ROUNDS(ROUNDS), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (blk_we),
    .key_we   (key_we),
    .key_addr (key_idx[M-1:1]),
    .rd_addr  (rd_addr),
    .load_en  (load_en),
    .round_en (round_en),
    .final_en (final_en),
    .key_wr_ok(key_wr_ok),
    .done     (done)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic bank_we;
    assign bank_we = key_wr_ok && (key_idx[0] == 1'(g));
    wmc_key_bank #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk  (clk),
      .we   (bank_we),
      .addr (rd_addr),
      .wdata(key_data),
      .rdata(key_rd[g])
    );
  end

  logic [W-1:0] wa_q, wb_q, wc_q, wd_q;
  logic [W-1:0] wa_d, wb_d, wc_d, wd_d;
  logic [W-1:0] ra, rb, rc, rd;
  logic         words_en;
  logic [4*W-1:0] out_q, out_d;

  wmc_round #(.W(W), .K(K)) u_round (
    .a_i     (wa_q),
    .b_i     (wb_q),
    .c_i     (wc_q),
    .d_i     (wd_q),
    .key_even(key_rd[0]),
    .key_odd (key_rd[1]),
    .a_o     (ra),
    .b_o     (rb),
    .c_o     (rc),
    .d_o     (rd)
  );

  always_comb begin
    words_en = load_en || round_en;
    if (load_en) begin
      wa_d = blk_in[4*W-1:3*W];
      wb_d = blk_in[3*W-1:2*W] + key_rd[0];
      wc_d = blk_in[2*W-1:W];
      wd_d = blk_in[W-1:0] + key_rd[1];
    end else begin
      wa_d = ra;
      wb_d = rb;
      wc_d = rc;
      wd_d = rd;
    end
    out_d = out_q;
    if (final_en) begin
      out_d = {wa_q + key_rd[0], wb_q, wc_q + key_rd[1], wd_q};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wa_q  <= '0;
      wb_q  <= '0;
      wc_q  <= '0;
      wd_q  <= '0;
      out_q <= '0;
    end else begin
      if (words_en) begin
        wa_q <= wa_d;
        wb_q <= wb_d;
        wc_q <= wc_d;
        wd_q <= wd_d;
      end
      if (final_en) begin
        out_q <= out_d;
      end
    end
  end

  assign blk_out = out_q;

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> $stable(blk_out));
  assert_no_mixed_ops_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({load_en, round_en, final_en, key_wr_ok}));
endmodule

// File: tb/wordmix_cipher_bench.sv
`timescale 1ns/1ps
module wordmix_cipher_bench;
  localparam int W  = 8;
  localparam int R  = 8;
  localparam int NK = 2 * R + 4;
  localparam int M  = $clog2(NK);
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0123_4567,
                                       32'h89AB_CDEF, 32'h8000_0001, 32'h5A5A_A5A5};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  key_data;
  logic [M-1:0]  key_idx;
  logic          key_we;
  logic [31:0]   blk_in;
  logic          blk_we;
  logic [31:0]   blk_out;
  logic          done;

  int nchecks = 0;
  int nerr    = 0;
  logic [7:0] keys [NK];

  always #4 clk = ~clk;

  wordmix_cipher #(.W(W), .ROUNDS(R)) u_wordmix_cipher (
    .clk(clk), .rst_n(rst_n), .key_data(key_data), .key_idx(key_idx), .key_we(key_we),
    .blk_in(blk_in), .blk_we(blk_we), .blk_out(blk_out), .done(done)
  );

  function automatic logic [7:0] rl8(input logic [7:0] x, input logic [2:0] s);
    logic [15:0] t;
    t = {x, x} << s;
    return t[15:8];
  endfunction

  function automatic logic [31:0] model(input logic [31:0] blk);
    logic [7:0] a, b, c, d, t, u, sq, tmp;
    a = blk[31:24]; b = blk[23:16] + keys[0]; c = blk[15:8]; d = blk[7:0] + keys[1];
    for (int i = 1; i <= R; i++) begin
      sq = b * {b[6:0], 1'b1}; t = rl8(sq, 3'd3);
      sq = d * {d[6:0], 1'b1}; u = rl8(sq, 3'd3);
      a = rl8(a ^ t, u[2:0]) + keys[2*i];
      c = rl8(c ^ u, t[2:0]) + keys[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + keys[2*R+2];
    c = c + keys[2*R+3];
    return {a, b, c, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_key(input int idx, input logic [7:0] val);
    key_idx = M'(idx); key_data = val; key_we = 1'b1;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  // Starts a block at a negedge; returns at the negedge after done should pulse.
  task automatic run_block(input logic [31:0] blk, input logic [31:0] exp, input string tag);
    bit early;
    blk_in = blk; blk_we = 1'b1;
    @(negedge clk);
    blk_we = 1'b0;
    early = 1'b0;
    for (int c = 0; c <= R; c++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    chk(!early, {tag, " R6 done early"}, 32'(early), 32'd0);
    chk(done === 1'b1, {tag, " R6 done at r+2"}, 32'(done), 32'd1);
    chk(blk_out === exp, {tag, " R4 R5 ciphertext"}, blk_out, exp);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 done one cycle"}, 32'(done), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    logic [31:0] exp, keep;
    bit extra;
    rst_n = 1'b0; key_we = 1'b0; blk_we = 1'b0; key_idx = '0; key_data = '0; blk_in = '0;
    for (int i = 0; i < NK; i++) keys[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(blk_out === 32'd0, "R1 out zero in reset", blk_out, 32'd0);
    chk(done === 1'b0, "R1 done low in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(blk_out === 32'd0 && done === 1'b0, "R1 after release", blk_out, 32'd0);

    // R2: fill both banks in scrambled order (odd keys first)
    for (int i = 1; i < NK; i += 2) put_key(i, keys[i]);
    for (int i = 0; i < NK; i += 2) put_key(i, keys[i]);
    chk(blk_out === 32'd0, "R7 zero before first encryption", blk_out, 32'd0);

    // Table-driven runs: R3, R4, R5, R6
    for (int v = 0; v < NV; v++) run_block(VEC[v], model(VEC[v]), "R3 vector");

    // R7: output holds while idle
    keep = blk_out;
    repeat (5) @(negedge clk);
    chk(blk_out === keep, "R7 hold while idle", blk_out, keep);

    // R8: second start mid-run is ignored
    exp = model(32'hCAFE_0042);
    blk_in = 32'hCAFE_0042; blk_we = 1'b1;
    @(negedge clk);
    blk_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(blk_out === keep, "R7 hold while running", blk_out, keep);
    blk_in = 32'h1111_2222; blk_we = 1'b1;
    @(negedge clk);
    blk_we = 1'b0;
    repeat (R - 2) @(negedge clk);
    chk(done === 1'b1, "R8 done timing kept", 32'(done), 32'd1);
    chk(blk_out === exp, "R8 first block result", blk_out, exp);
    extra = 1'b0;
    for (int c = 0; c < R + 4; c++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    chk(!extra, "R8 no second done", 32'(extra), 32'd0);

    // R9: key writes during a run and with start are dropped
    exp = model(32'h0BAD_F00D);
    blk_in = 32'h0BAD_F00D; blk_we = 1'b1;
    key_idx = M'(1); key_data = 8'hE7; key_we = 1'b1;
    @(negedge clk);
    blk_we = 1'b0;
    key_idx = M'(NK - 1); key_data = 8'h3C;
    @(negedge clk);
    key_idx = M'(NK - 2); key_data = 8'hC3;
    @(negedge clk);
    key_we = 1'b0;
    repeat (R - 1) @(negedge clk);
    chk(done === 1'b1 && blk_out === exp, "R9 keys frozen in run", blk_out, exp);
    @(negedge clk);
    run_block(32'h7777_1234, model(32'h7777_1234), "R9 keys unchanged");

    // R2: rewrite keys in each bank while idle and confirm they take effect
    keys[NK-1] = 8'h96; keys[NK-2] = 8'h1F; keys[4] = 8'hD2; keys[1] = 8'h08;
    put_key(NK - 1, keys[NK-1]);
    put_key(NK - 2, keys[NK-2]);
    put_key(4, keys[4]);
    put_key(1, keys[1]);
    run_block(32'h0F1E_2D3C, model(32'h0F1E_2D3C), "R2 rewritten keys");
    run_block(32'h0000_0000, model(32'h0000_0000), "R2 zero block");

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule